// File: doc/BRIEF.md
# Signed residue-to-binary converter

This block turns a signed integer held as a set of residues into an ordinary two's complement word. The residues belong to a set of pairwise coprime moduli whose last member is a power of two, 2^h, and whose product is M. The representable values run from -M/2 to M/2-1. Residue lane i carries X mod m_i, always written as a non-negative number below m_i.

The residues are first shifted by P = M/2, which makes the value non-negative. Each lane then looks up a scaled Chinese Remainder term. A carry-save tree adds these terms. The low k bits of the sum, where k = ceil(log2(number of moduli)), select one multiple of M/2^h from a small table. After that multiple is subtracted, the sum divides exactly by 2^k and gives the upper part of the shifted value. The low h bits come straight from the shifted power-of-two residue. A last step removes the offset. Both candidates, -P and M-P, are formed in parallel, and the sign of the upper part picks one of them.

The design has two register stages and accepts one conversion every cycle. It is built for a back end that takes filter results out of residue form. The default moduli set is {3, 5, 7, 8}, which gives M = 840, h = 3 and k = 2.

Top module: `rns_to_bin_signed`

## Requirements
- R1: valid_o is high exactly two rising clock edges after a cycle in which valid_i was high, and is low two edges after a cycle in which valid_i was low.
- R2: For every X in [-M/2, M/2-1], driving lane i of res_i with X mod m_i (non-negative, lane 0 least significant in the packed port, default lanes 3, 5, 7, 8) produces bin_o equal to X in OUT_W-bit two's complement, where OUT_W = ceil(log2 M), 10 bits by default.
- R3: The low h bits of each converted bin_o equal the low h bits of the power-of-two lane's residue.
- R4: With the default set, the residues (1, 1, 1, 7) on lanes (3, 5, 7, 8) convert to -209.
- R5: The range ends convert correctly: (0, 0, 0, 4) gives -420 and (2, 4, 6, 3) gives 419. Zero gives 0, and (2, 4, 6, 7) gives -1.
- R6: While valid_i stays low, bin_o keeps the last converted value.
- R7: An asserted rst_ni (active low, asynchronous) clears valid_o and bin_o to zero without waiting for a clock edge.
- R8: Back-to-back valid inputs on consecutive cycles produce back-to-back results in the same order, with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Residue set on res_i is valid |
| res_i | input | N_MOD*RES_W | Packed residues, lane i holds X mod MODULI[i] |
| valid_o | output | 1 | bin_o holds a new result |
| bin_o | output | OUT_W | Signed binary result |

## Verification
The whole signed range of the default set is streamed back to back. This covers every address of the multiple table and both outcomes of the sign selection, and each result is compared with the integer that produced the residues. A short table of single conversions runs the worked example, zero, minus one and both range ends. These separate an error in the offset correction from an error in the scaled sums. Idle gaps and a reset in the middle of a run show that the result is held and that it clears.

// File: rtl/rns2b_pkg.sv
`timescale 1ns/1ps
package rns2b_pkg;

  // Multiplicative inverse of a modulo m by search (small moduli only).
  function automatic int inv_mod(input int a, input int m);
    int r;
    r = 0;
    for (int t = 1; t < m; t++) begin
      if (((a % m) * t) % m == 1 && r == 0) r = t;
    end
    return r;
  endfunction

endpackage

// File: rtl/rns2b_lane_lut.sv
`timescale 1ns/1ps
module rns2b_lane_lut #(
  parameter int MOD     = 3,
  parameter int MHAT    = 280,
  parameter int MT      = 105,
  parameter int H       = 3,
  parameter int K       = 2,
  parameter int P       = 420,
  parameter bit IS_POW2 = 1'b0,
  parameter int RES_W   = 3,
  parameter int SUM_W   = 12
) (
  input  logic [RES_W-1:0]        res_i,
  output logic signed [SUM_W-1:0] term_o
);
  import rns2b_pkg::*;

  localparam int INV  = inv_mod(MHAT % MOD, MOD);
  localparam int PMOD = P % MOD;

  // Term scaled down by 2^H; exact for both lane kinds.
  function automatic int lut_term(input int e);
    int y;
    int c;
    y = (e + PMOD) % MOD;
    c = (INV * (1 << K) * y) % MOD;
    if (IS_POW2) return (MT * c - (1 << K) * y) / (1 << H);
    else         return (MHAT / (1 << H)) * c;
  endfunction

  always_comb begin
    term_o = '0;
    for (int e = 0; e < MOD; e++) begin
      if (res_i == RES_W'(e)) term_o = SUM_W'(lut_term(e));
    end
  end

endmodule

// File: rtl/rns2b_csa_tree.sv
`timescale 1ns/1ps
module rns2b_csa_tree #(
  parameter int NUM = 4,
  parameter int W   = 12
) (
  input  logic [NUM-1:0][W-1:0] in_i,
  output logic [W-1:0]          sum_o,
  output logic [W-1:0]          carry_o
);

  if (NUM == 1) begin : g_one
    assign sum_o   = in_i[0];
    assign carry_o = '0;
  end else if (NUM == 2) begin : g_two
    assign sum_o   = in_i[0];
    assign carry_o = in_i[1];
  end else begin : g_chain
    logic [W-1:0] s_q [1:NUM-1];
    logic [W-1:0] c_q [1:NUM-1];
    assign s_q[1] = in_i[0];
    assign c_q[1] = in_i[1];
    for (genvar j = 2; j < NUM; j++) begin : g_csa
      logic [W-1:0] maj;
      assign s_q[j] = s_q[j-1] ^ c_q[j-1] ^ in_i[j];
      assign maj    = (s_q[j-1] & c_q[j-1]) | (s_q[j-1] & in_i[j]) | (c_q[j-1] & in_i[j]);
      assign c_q[j] = {maj[W-2:0], 1'b0};
    end
    assign sum_o   = s_q[NUM-1];
    assign carry_o = c_q[NUM-1];
  end

endmodule

// File: rtl/rns2b_final.sv
`timescale 1ns/1ps
module rns2b_final #(
  parameter int MT    = 105,
  parameter int M     = 840,
  parameter int P     = 420,
  parameter int H     = 3,
  parameter int K     = 2,
  parameter int SUM_W = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [SUM_W-1:0] carry_i,
  input  logic [H-1:0]     yl_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] bin_o
);
  import rns2b_pkg::*;

  localparam int INV_MT = inv_mod(MT, 1 << K);
  localparam int XW     = SUM_W + H + 1;

  function automatic int mult_of(input int a);
    return ((a * INV_MT) % (1 << K)) * MT;
  endfunction

  logic signed [SUM_W-1:0] htil, mul, diff, eps;
  logic signed [XW-1:0]    xp, cand_pos, cand_neg;
  logic [OUT_W-1:0]        bin_d;

  assign htil = $signed(sum_i + carry_i);

  always_comb begin
    mul = '0;
    for (int a = 0; a < (1 << K); a++) begin
      if (htil[K-1:0] == K'(a)) mul = SUM_W'(mult_of(a));
    end
  end

  assign diff     = htil - mul;
  assign eps      = diff >>> K;
  assign xp       = (XW'(eps) <<< H) + $signed({{(XW-H){1'b0}}, yl_i});
  assign cand_pos = xp - XW'(P);
  assign cand_neg = xp + XW'(M - P);
  assign bin_d    = eps[SUM_W-1] ? OUT_W'(cand_neg) : OUT_W'(cand_pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bin_o   <= '0;
    end else begin
      valid_o <= v_i;
      if (v_i) bin_o <= bin_d;
    end
  end

  // R2: chosen multiple makes the sum divisible by 2^K
  p_low_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |-> (diff[K-1:0] == '0));
  // R2: scaled upper part lies within one range step of its reduced value
  p_eps_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |-> (int'(eps) >= -MT && int'(eps) < MT));
  // R2: result inside the signed range
  p_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (int'($signed(bin_o)) >= -P && int'($signed(bin_o)) < P));
  // R6: no update without valid
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_i |=> $stable(bin_o));

endmodule

// File: rtl/rns_to_bin_signed.sv
`timescale 1ns/1ps
module rns_to_bin_signed #(
  parameter int                   N_MOD  = 4,
  parameter logic [N_MOD-1:0][7:0] MODULI = {8'd8, 8'd7, 8'd5, 8'd3},
  localparam int                  RES_W  = res_width(),
  localparam int                  OUT_W  = $clog2(prod_mod())
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [N_MOD-1:0][RES_W-1:0]  res_i,
  output logic                         valid_o,
  output logic [OUT_W-1:0]             bin_o
);

  function automatic int prod_mod();
    int p;
    p = 1;
    for (int i = 0; i < N_MOD; i++) p = p * int'(MODULI[i]);
    return p;
  endfunction

  function automatic int res_width();
    int w;
    w = 1;
    for (int i = 0; i < N_MOD; i++) if ($clog2(int'(MODULI[i])) > w) w = $clog2(int'(MODULI[i]));
    return w;
  endfunction

  localparam int M     = prod_mod();
  localparam int P     = M / 2;
  localparam int H     = $clog2(int'(MODULI[N_MOD-1]));
  localparam int MT    = M >> H;
  localparam int K     = $clog2(N_MOD);
  localparam int SUM_W = $clog2(N_MOD * MT) + 3;
  localparam int PLOW  = P % (1 << H);

  logic [N_MOD-1:0][SUM_W-1:0] terms;
  logic [SUM_W-1:0]            sum_d, carry_d, sum_q, carry_q;
  logic [H-1:0]                yl_d, yl_q;
  logic                        v_q;

  for (genvar g = 0; g < N_MOD; g++) begin : g_lane
    localparam int MOD_G = int'(MODULI[g]);
    rns2b_lane_lut #(
      .MOD(MOD_G), .MHAT(M / MOD_G), .MT(MT), .H(H), .K(K), .P(P),
      .IS_POW2(g == N_MOD - 1), .RES_W(RES_W), .SUM_W(SUM_W)
    ) i_lut (
      .res_i (res_i[g]),
      .term_o(terms[g])
    );
  end

  rns2b_csa_tree #(.NUM(N_MOD), .W(SUM_W)) i_tree (
    .in_i   (terms),
    .sum_o  (sum_d),
    .carry_o(carry_d)
  );

  assign yl_d = res_i[N_MOD-1][H-1:0] + H'(PLOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      sum_q   <= '0;
      carry_q <= '0;
      yl_q    <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        sum_q   <= sum_d;
        carry_q <= carry_d;
        yl_q    <= yl_d;
      end
    end
  end

  rns2b_final #(
    .MT(MT), .M(M), .P(P), .H(H), .K(K), .SUM_W(SUM_W), .OUT_W(OUT_W)
  ) i_final (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (v_q),
    .sum_i  (sum_q),
    .carry_i(carry_q),
    .yl_i   (yl_q),
    .valid_o(valid_o),
    .bin_o  (bin_o)
  );

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
  p_low_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 (bin_o[H-1:0] == $past(res_i[N_MOD-1][H-1:0], 2)));

endmodule

// File: tb/test_rns_to_bin_signed.sv
`timescale 1ns/1ps
module test_rns_to_bin_signed;

  localparam int OUT_W = 10;
  localparam int RES_W = 3;
  localparam int HALF  = 420;
  localparam int MODS [0:3] = '{3, 5, 7, 8};
  localparam int NVEC = 8;
  // r(mod 3), r(mod 5), r(mod 7), r(mod 8), expected X
  localparam int VEC [0:NVEC-1][0:4] = '{
    '{1, 1, 1, 7, -209},
    '{0, 0, 0, 0, 0},
    '{2, 4, 6, 7, -1},
    '{2, 4, 6, 3, 419},
    '{0, 0, 0, 4, -420},
    '{1, 0, 2, 4, 100},
    '{2, 0, 5, 4, -100},
    '{1, 1, 1, 1, 1}
  };

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic                      valid_i = 1'b0;
  logic [3:0][RES_W-1:0]     res_i = '0;
  logic                      valid_o;
  logic [OUT_W-1:0]          bin_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  rns_to_bin_signed i_rns_to_bin_signed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .res_i  (res_i),
    .valid_o(valid_o),
    .bin_o  (bin_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int sres(input int x, input int m);
    return ((x % m) + m) % m;
  endfunction

  function automatic int outv();
    return int'($signed(bin_o));
  endfunction

  task automatic drive_x(input int x);
    for (int i = 0; i < 4; i++) res_i[i] = RES_W'(sres(x, MODS[i]));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int px [0:1];
    bit pv [0:1];
    int last;
    repeat (3) @(negedge clk_i);
    // R7: reset state
    chk("R7 valid_o after reset", int'(valid_o), 0);
    chk("R7 bin_o after reset", outv(), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Vector table, one conversion at a time
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      int xv;
      xv = VEC[v][4];
      tag = (v == 0) ? "R4" : ((xv == 419 || xv == -420 || xv == 0 || xv == -1) ? "R5" : "R2");
      for (int i = 0; i < 4; i++) res_i[i] = RES_W'(VEC[v][i]);
      valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
      @(negedge clk_i);
      chk("R1 valid_o after two edges", int'(valid_o), 1);
      chk(tag, outv(), xv);
      chk("R3 low bits", int'(bin_o[2:0]), VEC[v][3]);
      @(negedge clk_i);
      chk("R1 valid_o low when idle", int'(valid_o), 0);
      chk("R6 hold", outv(), xv);
    end

    // R8/R2/R3: full signed range streamed back to back
    pv[0] = 1'b0; pv[1] = 1'b0; px[0] = 0; px[1] = 0;
    for (int x = -HALF; x < HALF + 2; x++) begin
      if (pv[1]) begin
        chk("R8 valid_o streaming", int'(valid_o), 1);
        chk("R2 sweep", outv(), px[1]);
        chk("R3 sweep low bits", int'(bin_o[2:0]), sres(px[1], 8));
      end
      pv[1] = pv[0]; px[1] = px[0];
      if (x < HALF) begin
        drive_x(x);
        valid_i = 1'b1;
        pv[0] = 1'b1; px[0] = x;
      end else begin
        valid_i = 1'b0;
        pv[0] = 1'b0;
      end
      @(negedge clk_i);
    end

    // R6: long idle keeps the last result
    last = HALF - 1;
    drive_x(-5);
    repeat (4) @(negedge clk_i);
    chk("R6 hold after idle", outv(), last);
    chk("R1 idle valid_o", int'(valid_o), 0);

    // R7: asynchronous reset in the middle of operation
    drive_x(-300);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R2 before reset", outv(), -300);
    #3 rst_ni = 1'b0;
    #1;
    chk("R7 async valid_o", int'(valid_o), 0);
    chk("R7 async bin_o", outv(), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule